// File: doc/BRIEF.md
# Packed Saturating Add/Subtract Unit

This block is one slice of a media ALU. It takes a pair of 64-bit operands and treats each one as a row of equal lanes, 1, 2, 4 or 8 bytes wide. It adds or subtracts the lanes pairwise. A lane never passes a carry or a borrow into its neighbour. A two-bit control field chooses how a lane result that does not fit is handled: it can wrap modulo the lane width, clamp as an unsigned number, or clamp as a two's-complement number.

Each operation is presented for one cycle together with a valid strobe. The result comes out of a register one clock later with its own valid strobe. To process a 128-bit register, issue the operation twice, once for each half.

The reset input is asynchronous and active low. It clears the outputs at once. The block leaves reset two clock edges after the input is released.

Top module: `simd_satarith`

## Requirements
- R1: While reset is held, and after it until the first accepted operation, `res_valid` is 0 and `res_data` is all zeros.
- R2: An operation presented with `op_valid` high at a rising edge appears on `res_data` after that edge, with `res_valid` high for exactly that cycle. `res_valid` is 0 after an edge where `op_valid` was low.
- R3: At an edge where `op_valid` is low, `res_data` keeps its previous value.
- R4: `lane_bytes` gives the lane width in bytes. The value 1 selects 8-bit lanes, 2 selects 16-bit lanes and 4 selects 32-bit lanes. Any other value selects one 64-bit lane. Lane k occupies bits [k*W +: W].
- R5: When control bit 1 (saturate) is 0, every lane result is the sum or difference modulo 2^W, whatever the value of control bit 6 (signed).
- R6: Lanes are independent. A carry or borrow never crosses a lane boundary.
- R7: Control bit 1 = 1 with bit 6 = 0 gives an unsigned add. A lane whose sum carries out of the lane is set to all ones.
- R8: Control bit 1 = 1 with bit 6 = 0 gives an unsigned subtract. A lane whose second operand is larger than its first is set to zero.
- R9: Control bits 1 and 6 both set give a signed add. A lane overflows when both operand signs match and the wrapped sign differs from them. An overflowing lane becomes the most negative value if the wrapped sign is 0, and the most positive value otherwise.
- R10: With control bits 1 and 6 both set, a signed subtract uses the overflow test of R9 with the second operand's sign inverted, and clamps the same way.
- R11: Control bits other than 1 and 6 have no effect on the result.
- R12: `op_sub` = 1 selects subtraction (first minus second operand); `op_sub` = 0 selects addition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Operation strobe |
| op_sub | input | 1 | 1 = subtract, 0 = add |
| lane_bytes | input | 4 | Lane width in bytes (1, 2, 4, other = 8) |
| ctrl | input | 8 | Mode flags: bit 1 saturate, bit 6 signed |
| src_a | input | 64 | First operand |
| src_b | input | 64 | Second operand |
| res_valid | output | 1 | Result strobe, one cycle after `op_valid` |
| res_data | output | 64 | Registered lane-wise result |

## Verification
The lane assertions look only at 8-bit lane mode. They assume that `op_valid`, `op_sub`, `ctrl` and the operands are stable around the rising edge and are not unknown. They also compare the registered result against the operands seen at the previous edge.

The stimulus meets these assumptions. It changes every input only on the falling edge, and it holds each operation for exactly one cycle. It draws lane widths from the four legal codes plus illegal ones, and it mixes random operands with directed lane-edge values, such as the largest positive byte plus one and the most negative byte minus one.

// File: rtl/satarith_pkg.sv
package satarith_pkg;
  localparam int CTRL_W      = 8;
  localparam int CTL_SAT_BIT = 1;
  localparam int CTL_SGN_BIT = 6;
  localparam int NUM_WIDTHS  = 4;

  typedef enum logic [1:0] {
    LW_8  = 2'd0,
    LW_16 = 2'd1,
    LW_32 = 2'd2,
    LW_64 = 2'd3
  } lane_w_e;

  function automatic lane_w_e decode_lane(input logic [3:0] nbytes);
    case (nbytes)
      4'd1:    decode_lane = LW_8;
      4'd2:    decode_lane = LW_16;
      4'd4:    decode_lane = LW_32;
      default: decode_lane = LW_64;
    endcase
  endfunction
endpackage

// File: rtl/sat_lane.sv
module sat_lane #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         do_sub,
  input  logic         sat,
  input  logic         sgn,
  output logic [W-1:0] y
);
  localparam logic [W-1:0] UMAX = {W{1'b1}};
  localparam logic [W-1:0] SMAX = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] SMIN = {1'b1, {(W-1){1'b0}}};

  logic [W:0]   ext;
  logic [W-1:0] raw;
  logic         cout;
  logic         b_sign;
  logic         ovf;

  always_comb begin
    ext    = {1'b0, a} + {1'b0, b ^ {W{do_sub}}} + {{W{1'b0}}, do_sub};
    raw    = ext[W-1:0];
    cout   = ext[W];
    b_sign = b[W-1] ^ do_sub;
    ovf    = (a[W-1] == b_sign) && (raw[W-1] != a[W-1]);
    y      = raw;
    if (sat) begin
      if (sgn) begin
        if (ovf) y = raw[W-1] ? SMAX : SMIN;
      end else begin
        if (!do_sub && cout) y = UMAX;
        if (do_sub && !cout) y = '0;
      end
    end
  end
endmodule

// File: rtl/lane_bank.sv
module lane_bank #(
  parameter int DATA_W = 64,
  parameter int LANE_W = 8
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic              do_sub,
  input  logic              sat,
  input  logic              sgn,
  output logic [DATA_W-1:0] y
);
  localparam int NLANES = DATA_W / LANE_W;

  for (genvar i = 0; i < NLANES; i++) begin : g_lane
    sat_lane #(.W(LANE_W)) u_lane (
      .a      (a[i*LANE_W +: LANE_W]),
      .b      (b[i*LANE_W +: LANE_W]),
      .do_sub (do_sub),
      .sat    (sat),
      .sgn    (sgn),
      .y      (y[i*LANE_W +: LANE_W])
    );
  end
endmodule

// File: rtl/rst_sync.sv
module rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_s
);
  logic [1:0] stage_q;
  logic [1:0] stage_d;

  always_comb stage_d = {stage_q[0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= '0;
    else        stage_q <= stage_d;
  end

  assign rst_s = stage_q[1];
endmodule

// File: rtl/res_reg.sv
module res_reg #(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [W-1:0] d,
  output logic         v_q,
  output logic [W-1:0] q
);
  logic [W-1:0] q_nxt;
  logic         v_nxt;

  always_comb begin
    q_nxt = en ? d : q;
    v_nxt = en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q   <= '0;
      v_q <= 1'b0;
    end else begin
      q   <= q_nxt;
      v_q <= v_nxt;
    end
  end

  assert_valid_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    en |=> v_q);
  assert_valid_drops_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !v_q);
  assert_hold_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(q));
endmodule

// File: rtl/simd_satarith.sv
module simd_satarith
  import satarith_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_valid,
  input  logic              op_sub,
  input  logic [3:0]        lane_bytes,
  input  logic [CTRL_W-1:0] ctrl,
  input  logic [DATA_W-1:0] src_a,
  input  logic [DATA_W-1:0] src_b,
  output logic              res_valid,
  output logic [DATA_W-1:0] res_data
);
  localparam int NBYTES = DATA_W / 8;

  logic              rst_s;
  logic              sat;
  logic              sgn;
  lane_w_e           lane_sel;
  logic [DATA_W-1:0] by_w [NUM_WIDTHS];
  logic [DATA_W-1:0] sel_y;
  logic              ctrl_unused;

  rst_sync u_rst (
    .clk   (clk),
    .rst_n (rst_n),
    .rst_s (rst_s)
  );

  always_comb begin
    sat      = ctrl[CTL_SAT_BIT];
    sgn      = ctrl[CTL_SGN_BIT];
    lane_sel = decode_lane(lane_bytes);
    sel_y    = by_w[int'(lane_sel)];
  end

  assign ctrl_unused = ^{ctrl[CTRL_W-1:CTL_SGN_BIT+1],
                         ctrl[CTL_SGN_BIT-1:CTL_SAT_BIT+1], ctrl[0]};

  for (genvar k = 0; k < NUM_WIDTHS; k++) begin : g_width
    lane_bank #(.DATA_W(DATA_W), .LANE_W(8 << k)) u_bank (
      .a      (src_a),
      .b      (src_b),
      .do_sub (op_sub),
      .sat    (sat),
      .sgn    (sgn),
      .y      (by_w[k])
    );
  end

  res_reg #(.W(DATA_W)) u_out (
    .clk   (clk),
    .rst_n (rst_s),
    .en    (op_valid),
    .d     (sel_y),
    .v_q   (res_valid),
    .q     (res_data)
  );

  for (genvar i = 0; i < NBYTES; i++) begin : g_chk
    assert_usat_add_floor_R7: assert property (@(posedge clk) disable iff (!rst_s)
      (op_valid && !op_sub && sat && !sgn && lane_bytes == 4'd1)
      |=> res_data[8*i +: 8] >= $past(src_a[8*i +: 8]));
    assert_usat_sub_ceiling_R8: assert property (@(posedge clk) disable iff (!rst_s)
      (op_valid && op_sub && sat && !sgn && lane_bytes == 4'd1)
      |=> res_data[8*i +: 8] <= $past(src_a[8*i +: 8]));
    assert_ssat_sign_kept_R9: assert property (@(posedge clk) disable iff (!rst_s)
      (op_valid && !op_sub && sat && sgn && lane_bytes == 4'd1 &&
       src_a[8*i+7] == src_b[8*i+7])
      |=> res_data[8*i+7] == $past(src_a[8*i+7]));
  end
endmodule

// File: tb/simd_satarith_test.sv
module simd_satarith_test;
  localparam int PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_valid = 1'b0;
  logic        op_sub = 1'b0;
  logic [3:0]  lane_bytes = 4'd1;
  logic [7:0]  ctrl = 8'd0;
  logic [63:0] src_a = '0;
  logic [63:0] src_b = '0;
  logic        res_valid;
  logic [63:0] res_data;

  int          n_checks = 0;
  int          n_fail = 0;
  logic [63:0] exp_data = '0;
  bit          done = 1'b0;

  always #(PERIOD/2) clk = ~clk;

  simd_satarith uut (
    .clk, .rst_n, .op_valid, .op_sub, .lane_bytes, .ctrl,
    .src_a, .src_b, .res_valid, .res_data
  );

  function automatic logic [63:0] model(input logic [63:0] a, input logic [63:0] b,
                                        input logic [3:0] nb, input bit sub,
                                        input logic [7:0] c);
    int w;
    bit sat, sgn;
    logic [63:0] msk, ua, ub, res;
    logic signed [67:0] x, y, r, lo, hi;
    sat = c[1];
    sgn = c[6];
    w = (nb == 4'd1) ? 8 : (nb == 4'd2) ? 16 : (nb == 4'd4) ? 32 : 64;
    msk = (w == 64) ? '1 : ((64'd1 << w) - 64'd1);
    res = '0;
    for (int l = 0; l < 64 / w; l++) begin
      ua = (a >> (l * w)) & msk;
      ub = (b >> (l * w)) & msk;
      x = $signed({4'b0, ua});
      y = $signed({4'b0, ub});
      if (sat && sgn) begin
        if (ua[w-1]) x = x - (68'sd1 <<< w);
        if (ub[w-1]) y = y - (68'sd1 <<< w);
      end
      r = sub ? x - y : x + y;
      if (sat) begin
        if (sgn) begin
          lo = -(68'sd1 <<< (w - 1));
          hi = (68'sd1 <<< (w - 1)) - 68'sd1;
        end else begin
          lo = 68'sd0;
          hi = (68'sd1 <<< w) - 68'sd1;
        end
        if (r < lo) r = lo;
        if (r > hi) r = hi;
      end
      res = res | ((r[63:0] & msk) << (l * w));
    end
    return res;
  endfunction

  task automatic check(input string tag, input logic v_exp, input logic [63:0] d_exp);
    n_checks += 2;
    if (res_valid !== v_exp) begin
      n_fail++;
      $display("FAIL %s valid actual=%0b expected=%0b", tag, res_valid, v_exp);
    end
    if (res_data !== d_exp) begin
      n_fail++;
      $display("FAIL %s data actual=%h expected=%h", tag, res_data, d_exp);
    end
  endtask

  // drive at negedge, result registered at the posedge, sampled at next negedge
  task automatic step(input string tag, input bit v, input logic [63:0] a,
                      input logic [63:0] b, input logic [3:0] nb, input bit sub,
                      input logic [7:0] c);
    op_valid = v; src_a = a; src_b = b; lane_bytes = nb; op_sub = sub; ctrl = c;
    if (v) exp_data = model(a, b, nb, sub, c);
    @(negedge clk);
    check(tag, v, exp_data);
  endtask

  function automatic string mode_tag(input logic [7:0] c, input bit sub);
    if (!c[1]) return "R5";
    if (c[6]) return sub ? "R10" : "R9";
    return sub ? "R8" : "R7";
  endfunction

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL R2 watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    logic [63:0] ra, rb;
    logic [7:0]  rc;
    logic [3:0]  rn;
    bit          rs;
    repeat (3) @(negedge clk);
    check("R1", 1'b0, 64'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1", 1'b0, 64'd0);

    step("R9",  1, 64'h7F, 64'h01, 4'd1, 0, 8'h42);
    step("R9",  1, 64'h80, 64'hFF, 4'd1, 0, 8'h42);
    step("R10", 1, 64'h80, 64'h01, 4'd1, 1, 8'h42);
    step("R10", 1, 64'h7F, 64'hFF, 4'd1, 1, 8'h42);
    step("R7",  1, 64'hFF, 64'h01, 4'd1, 0, 8'h02);
    step("R8",  1, 64'h00, 64'h01, 4'd1, 1, 8'h02);
    step("R5",  1, 64'h7F, 64'h01, 4'd1, 0, 8'h00);
    step("R5",  1, 64'h7F, 64'h01, 4'd1, 0, 8'h40);
    step("R12", 1, 64'h0505, 64'h0302, 4'd1, 1, 8'h00);
    step("R3",  0, 64'h1234, 64'h5678, 4'd2, 0, 8'h02);
    step("R3",  0, '1, '1, 4'd8, 1, 8'h42);
    step("R6",  1, 64'h00FF, 64'h0001, 4'd2, 0, 8'h00);
    step("R6",  1, 64'h00FF, 64'h0001, 4'd1, 0, 8'h00);
    step("R6",  1, 64'h0000_0100, 64'h0000_0001, 4'd1, 1, 8'h02);
    step("R4",  1, 64'h0000_0000_FFFF_FFFF, 64'h1, 4'd3, 0, 8'h00);
    step("R4",  1, 64'h0000_0000_FFFF_FFFF, 64'h1, 4'd4, 0, 8'h00);
    step("R4",  1, 64'h7FFF_FFFF_FFFF_FFFF, 64'h1, 4'd8, 0, 8'h42);
    step("R4",  1, 64'h8000_0000_0000_0000, 64'h1, 4'd0, 1, 8'h42);
    step("R11", 1, 64'h7F, 64'h01, 4'd1, 0, 8'hBD);
    step("R11", 1, 64'h7F, 64'h01, 4'd1, 0, 8'hFF);
    step("R11", 1, 64'hFF, 64'h01, 4'd1, 0, 8'hBF);

    for (int i = 0; i < 400; i++) begin
      ra = {$urandom, $urandom};
      rb = {$urandom, $urandom};
      if (i % 5 == 0) begin
        ra = ra & 64'h8181_8181_8181_8181 | 64'h7E7E_7E7E_0000_0000;
        rb = rb & 64'h0101_0101_8080_8080;
      end
      rc = 8'($urandom);
      rs = 1'($urandom);
      case ($urandom % 5)
        0: rn = 4'd1;
        1: rn = 4'd2;
        2: rn = 4'd4;
        3: rn = 4'd8;
        default: rn = 4'($urandom);
      endcase
      step(mode_tag(rc, rs), (i % 7) != 3, ra, rb, rn, rs, rc);
    end

    op_valid = 1'b0;
    rst_n = 1'b0;
    #1;
    n_checks += 2;
    if (res_valid !== 1'b0 || res_data !== 64'd0) begin
      n_fail++;
      $display("FAIL R1 async clear actual=%0b/%h expected=0/0", res_valid, res_data);
    end
    @(negedge clk);
    check("R1", 1'b0, 64'd0);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule